// File: doc/BRIEF.md
# Memory Row Sequencer with Row Clock

This block walks through the rows of an analog sample store while a record, playback or fast-forward operation runs. The command side supplies a start row and an operation code. The sequencer then times each row from a clock-enable tick. For every row it drives an open-drain row clock that is released (high) for a long phase and pulled low for a short phase. The current row number steps forward when the row clock falls.

An operation ends in one of three ways. A stop request ends it at the next row boundary. In playback only, a detected end marker does the same and also emits a one-cycle end-of-message pulse. If the last row's high phase completes, the operation ends and emits a one-cycle overflow pulse. While idle, the row clock stays released and the row number holds. All row timing counts ticks, so a bench can run the block with a tick on every cycle.

Top module: `row_sweep_seq`

## Requirements
- R1: After reset, busy is 0, rowClkLow is 0, curRow is 0, and ovfPulse and eomPulse are 0.
- R2: opCode encodes 00 = none, 01 = record, 10 = playback and 11 = fast-forward. When startValid is high while idle, with a nonzero opCode and startRow below NUM_ROWS, the next cycle shows busy 1, curRow equal to startRow and the row clock released. A start is ignored when opCode is 00, when startRow is NUM_ROWS or above, or while busy.
- R3: In record and playback, each row is NORM_HIGH ticks released and then NORM_LOW ticks low. The defaults are 5600 and 800 ticks of 31.25 us, which give 175 ms and 25 ms.
- R4: In fast-forward, each row is FF_HIGH ticks released and then FF_LOW ticks low. The defaults are 7 and 1.
- R5: curRow increases by exactly one in the same cycle that rowClkLow rises. Apart from a start, it changes at no other time.
- R6: If the high phase of row NUM_ROWS-1 completes, then in the next cycle ovfPulse is 1 for one cycle, busy is 0, the row clock is released and curRow stays NUM_ROWS-1.
- R7: A stopReq seen while busy ends the operation when the current low phase completes. The row clock is released and curRow holds the row that phase announced.
- R8: In playback, eomDetect gives eomPulse = 1 in the following cycle, and the operation ends at the next row boundary as for a stop. In record and fast-forward, eomDetect is ignored.
- R9: The phase timers advance only in cycles where tick is 1. With tick held at 0, the current phase lasts longer by that many cycles.
- R10: While idle, rowClkLow stays 0 and curRow holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timing enable: one tick per time unit |
| startValid | input | 1 | Start an operation |
| opCode | input | 2 | Operation: 01 record, 10 playback, 11 fast-forward |
| startRow | input | ROW_W | First row of the operation |
| stopReq | input | 1 | End the operation at the next row boundary |
| eomDetect | input | 1 | End marker seen (used in playback) |
| curRow | output | ROW_W | Current row |
| rowClkLow | output | 1 | 1 = pull the open-drain row clock low, 0 = release it |
| busy | output | 1 | An operation is running |
| ovfPulse | output | 1 | One-cycle pulse on running off the last row |
| eomPulse | output | 1 | One-cycle end-of-message pulse |

## Verification
All outputs come from registers. A start shows on curRow and busy one cycle after the edge that samples it. A completed high phase makes rowClkLow and the new curRow appear at that same edge. When the low phase completes after a stop or end marker, busy falls at that edge. ovfPulse and eomPulse are due one edge after the high phase completes or the marker is sampled. The driver queues one expected snapshot per clock edge, counted from the start edge. The monitor pops one snapshot 5 ns after each rising edge, so every comparison lands on the exact cycle that the requirement fixes.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_REC  = 2'b01,
    OP_PLAY = 2'b10,
    OP_FFWD = 2'b11
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_HIGH = 2'b01,
    ST_LOW  = 2'b10
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRow;
    logic stepRow;
    logic clearCnt;
    logic countEn;
  } dpStrobe_t;

endpackage

// File: rtl/rowseq_dp.sv
module rowseq_dp
  import rowseq_pkg::*;
#(
  parameter int NUM_ROWS = 2400,
  parameter int ROW_W    = 12,
  parameter int CNT_W    = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [ROW_W-1:0] startRow,
  output logic [ROW_W-1:0] curRow,
  output logic             atLastRow,
  output logic [CNT_W-1:0] tickCnt
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curRow  <= '0;
      tickCnt <= '0;
    end else begin
      if (strobe.loadRow)      curRow <= startRow;
      else if (strobe.stepRow) curRow <= curRow + 1'b1;

      if (strobe.clearCnt)     tickCnt <= '0;
      else if (strobe.countEn) tickCnt <= tickCnt + 1'b1;
    end
  end

  assign atLastRow = (curRow == LAST_ROW);

  // R2: the row register never leaves the memory
  a_r2_row_bound: assert property (@(posedge clk) disable iff (!rstN)
    32'(curRow) < NUM_ROWS);

endmodule

// File: rtl/rowseq_ctrl.sv
module rowseq_ctrl
  import rowseq_pkg::*;
#(
  parameter int NORM_HIGH = 5600,
  parameter int NORM_LOW  = 800,
  parameter int FF_HIGH   = 7,
  parameter int FF_LOW    = 1,
  parameter int CNT_W     = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             startValid,
  input  logic [1:0]       opCode,
  input  logic             startRowOk,
  input  logic             stopReq,
  input  logic             eomDetect,
  input  logic             atLastRow,
  input  logic [CNT_W-1:0] tickCnt,
  output dpStrobe_t        strobe,
  output logic             rowClkLow,
  output logic             busy,
  output logic             ovfPulse,
  output logic             eomPulse
);

  localparam logic [CNT_W-1:0] NH_LAST = CNT_W'(NORM_HIGH - 1);
  localparam logic [CNT_W-1:0] NL_LAST = CNT_W'(NORM_LOW - 1);
  localparam logic [CNT_W-1:0] FH_LAST = CNT_W'(FF_HIGH - 1);
  localparam logic [CNT_W-1:0] FL_LAST = CNT_W'(FF_LOW - 1);

  phase_e  state, nextState;
  opcode_e mode;
  logic    stopPend;
  logic    hiDone, loDone, eomHit, startOk, isFast;

  assign isFast  = (mode == OP_FFWD);
  assign hiDone  = tick && (tickCnt == (isFast ? FH_LAST : NH_LAST));
  assign loDone  = tick && (tickCnt == (isFast ? FL_LAST : NL_LAST));
  assign eomHit  = (state != ST_IDLE) && (mode == OP_PLAY) && eomDetect;
  assign startOk = startValid && (opCode != OP_NONE) && startRowOk;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (startOk) begin
        strobe.loadRow  = 1'b1;
        strobe.clearCnt = 1'b1;
        nextState       = ST_HIGH;
      end
      ST_HIGH: begin
        strobe.countEn = tick;
        if (hiDone) begin
          strobe.clearCnt = 1'b1;
          if (atLastRow) nextState = ST_IDLE;
          else begin
            strobe.stepRow = 1'b1;
            nextState      = ST_LOW;
          end
        end
      end
      ST_LOW: begin
        strobe.countEn = tick;
        if (loDone) begin
          strobe.clearCnt = 1'b1;
          nextState = (stopPend || stopReq || eomHit) ? ST_IDLE : ST_HIGH;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      mode     <= OP_NONE;
      stopPend <= 1'b0;
      ovfPulse <= 1'b0;
      eomPulse <= 1'b0;
    end else begin
      state    <= nextState;
      if (strobe.loadRow) mode <= opcode_e'(opCode);
      if (nextState == ST_IDLE || state == ST_IDLE) stopPend <= 1'b0;
      else if (stopReq || eomHit)                   stopPend <= 1'b1;
      ovfPulse <= (state == ST_HIGH) && hiDone && atLastRow;
      eomPulse <= eomHit;
    end
  end

  assign rowClkLow = (state == ST_LOW);
  assign busy      = (state != ST_IDLE);

  // R6: overflow pulse only follows a completed high phase
  a_r6_ovf_after_high: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> ($past(busy) && !$past(rowClkLow) && !busy));

  // R8: end-of-message pulse only after a marker was seen
  a_r8_eom_needs_marker: assert property (@(posedge clk) disable iff (!rstN)
    eomPulse |-> $past(eomDetect));

endmodule

// File: rtl/row_sweep_seq.sv
module row_sweep_seq
  import rowseq_pkg::*;
#(
  parameter int NUM_ROWS  = 2400,
  parameter int NORM_HIGH = 5600,
  parameter int NORM_LOW  = 800,
  parameter int FF_HIGH   = 7,
  parameter int FF_LOW    = 1,
  parameter int ROW_W     = $clog2(NUM_ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             startValid,
  input  logic [1:0]       opCode,
  input  logic [ROW_W-1:0] startRow,
  input  logic             stopReq,
  input  logic             eomDetect,
  output logic [ROW_W-1:0] curRow,
  output logic             rowClkLow,
  output logic             busy,
  output logic             ovfPulse,
  output logic             eomPulse
);

  localparam int MAX_N = (NORM_HIGH > NORM_LOW) ? NORM_HIGH : NORM_LOW;
  localparam int MAX_F = (FF_HIGH > FF_LOW) ? FF_HIGH : FF_LOW;
  localparam int MAX_P = (MAX_N > MAX_F) ? MAX_N : MAX_F;
  localparam int CNT_W = $clog2(MAX_P + 1);

  dpStrobe_t        strobe;
  logic             atLastRow;
  logic [CNT_W-1:0] tickCnt;
  logic             startRowOk;

  assign startRowOk = (32'(startRow) < NUM_ROWS);

  rowseq_ctrl #(
    .NORM_HIGH(NORM_HIGH), .NORM_LOW(NORM_LOW),
    .FF_HIGH(FF_HIGH), .FF_LOW(FF_LOW), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .startValid(startValid),
    .opCode(opCode), .startRowOk(startRowOk), .stopReq(stopReq),
    .eomDetect(eomDetect), .atLastRow(atLastRow), .tickCnt(tickCnt),
    .strobe(strobe), .rowClkLow(rowClkLow), .busy(busy),
    .ovfPulse(ovfPulse), .eomPulse(eomPulse)
  );

  rowseq_dp #(
    .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startRow(startRow),
    .curRow(curRow), .atLastRow(atLastRow), .tickCnt(tickCnt)
  );

  // R10: an idle sequencer leaves the row clock released
  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rowClkLow);

  // R5: the row changes only as the row clock falls or on a start
  a_r5_row_moves_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curRow) |-> ((rowClkLow && !$past(rowClkLow)) || (busy && !$past(busy))));

  // R6: overflow is reported on the last row with the operation ended
  a_r6_ovf_on_last_row: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (32'(curRow) == NUM_ROWS - 1 && !busy && !rowClkLow));

endmodule

// File: tb/test_row_sweep_seq.sv
module test_row_sweep_seq;

  localparam int NR = 20, NH = 5, NL = 3, FH = 7, FL = 1, RW = 5;

  logic clk = 0, rstN = 0, tick = 1, startValid = 0, stopReq = 0, eomDetect = 0;
  logic [1:0] opCode = 0;
  logic [RW-1:0] startRow = 0;
  logic [RW-1:0] curRow;
  logic rowClkLow, busy, ovfPulse, eomPulse;

  int compared = 0, mismatched = 0;
  bit done = 0;

  typedef struct {
    logic [RW-1:0] row;
    logic low, bsy, ovf, eom;
    string req;
  } exp_t;
  exp_t q[$];
  exp_t e;

  always #10 clk = ~clk;

  row_sweep_seq #(.NUM_ROWS(NR), .NORM_HIGH(NH), .NORM_LOW(NL),
                  .FF_HIGH(FH), .FF_LOW(FL)) i_row_sweep_seq (
    .clk(clk), .rstN(rstN), .tick(tick), .startValid(startValid),
    .opCode(opCode), .startRow(startRow), .stopReq(stopReq),
    .eomDetect(eomDetect), .curRow(curRow), .rowClkLow(rowClkLow),
    .busy(busy), .ovfPulse(ovfPulse), .eomPulse(eomPulse)
  );

  task automatic push(input logic [RW-1:0] row, input logic low, input logic bsy,
                      input logic ovf, input logic eom, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      exp_t x;
      x.row = row; x.low = low; x.bsy = bsy; x.ovf = ovf; x.eom = eom; x.req = req;
      q.push_back(x);
    end
  endtask

  // monitor: one snapshot per rising edge, sampled 5 ns after it
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      e = q.pop_front();
      compared++;
      if (curRow !== e.row || rowClkLow !== e.low || busy !== e.bsy ||
          ovfPulse !== e.ovf || eomPulse !== e.eom) begin
        mismatched++;
        $display("FAIL %s: got row=%0d low=%b busy=%b ovf=%b eom=%b, exp row=%0d low=%b busy=%b ovf=%b eom=%b",
                 e.req, curRow, rowClkLow, busy, ovfPulse, eomPulse,
                 e.row, e.low, e.bsy, e.ovf, e.eom);
      end
    end
  end

  task automatic startOp(input logic [1:0] op, input logic [RW-1:0] row);
    startValid = 1; opCode = op; startRow = row;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout, exp completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    compared++;
    if (curRow !== 0 || rowClkLow !== 0 || busy !== 0 || ovfPulse !== 0 || eomPulse !== 0) begin
      mismatched++;
      $display("FAIL R1: got row=%0d low=%b busy=%b ovf=%b eom=%b, exp all 0",
               curRow, rowClkLow, busy, ovfPulse, eomPulse);
    end
    rstN = 1;
    @(negedge clk);

    // A: record from row 3, restart attempt while busy (R2), stop in high (R7); R3 R5 R10
    startOp(2'b01, 5'd3);
    push(5'd3, 0, 1, 0, 0, NH, "R3");
    push(5'd4, 1, 1, 0, 0, NL, "R5");
    push(5'd4, 0, 0, 0, 0, 3, "R7");
    @(negedge clk); startOp(2'b11, 5'd10);
    @(negedge clk); startValid = 0; stopReq = 1;
    @(negedge clk); stopReq = 0;
    drain();

    // E: starts that must be ignored (R2), idle hold (R10)
    startOp(2'b00, 5'd9);
    push(5'd4, 0, 0, 0, 0, 3, "R2");
    @(negedge clk); startOp(2'b01, 5'd25);
    @(negedge clk); startValid = 0;
    drain();

    // B: fast-forward into the last row, overflow (R4, R6)
    startOp(2'b11, 5'd17);
    push(5'd17, 0, 1, 0, 0, FH, "R4");
    push(5'd18, 1, 1, 0, 0, FL, "R4");
    push(5'd18, 0, 1, 0, 0, FH, "R4");
    push(5'd19, 1, 1, 0, 0, FL, "R5");
    push(5'd19, 0, 1, 0, 0, FH, "R4");
    push(5'd19, 0, 0, 1, 0, 1, "R6");
    push(5'd19, 0, 0, 0, 0, 2, "R6");
    @(negedge clk); startValid = 0;
    drain();

    // C: playback from 0, tick held low 3 cycles (R9), end marker in row 1 (R8)
    startOp(2'b10, 5'd0); tick = 0;
    push(5'd0, 0, 1, 0, 0, NH + 3, "R9");
    push(5'd1, 1, 1, 0, 0, NL, "R3");
    push(5'd1, 0, 1, 0, 0, 1, "R3");
    push(5'd1, 0, 1, 0, 1, 1, "R8");
    push(5'd1, 0, 1, 0, 0, NH - 2, "R8");
    push(5'd2, 1, 1, 0, 0, NL, "R8");
    push(5'd2, 0, 0, 0, 0, 2, "R8");
    @(negedge clk); startValid = 0;           // N1
    repeat (3) @(negedge clk); tick = 1;      // N4
    repeat (8) @(negedge clk); eomDetect = 1; // N12
    @(negedge clk); eomDetect = 0;
    drain();

    // D: record ignores end marker (R8), stop in second row (R7)
    startOp(2'b01, 5'd5);
    push(5'd5, 0, 1, 0, 0, NH, "R8");
    push(5'd6, 1, 1, 0, 0, NL, "R8");
    push(5'd6, 0, 1, 0, 0, NH, "R8");
    push(5'd7, 1, 1, 0, 0, NL, "R7");
    push(5'd7, 0, 0, 0, 0, 2, "R7");
    @(negedge clk); startValid = 0;           // N1
    @(negedge clk); eomDetect = 1;            // N2
    @(negedge clk); eomDetect = 0;
    repeat (6) @(negedge clk); stopReq = 1;   // N9
    @(negedge clk); stopReq = 0;
    drain();

    finishRun();
  end

endmodule